// File: doc/BRIEF.md
# Posted-Write Burst SRAM with Read Bypass

This block is a synchronous burst memory that delays every write to its storage array by one write operation. An accepted write burst is collected in a holding register together with its row address. The held burst is copied into the array only when the next write command is accepted, and that new write then takes the holding register's place. A read compares its row with the held row. On a match, the four words come from the holding register instead of the array. A read issued in the first free cycle after a write therefore sees the new data with no extra wait, and the delay in committing writes cannot be seen at the ports.

Each access moves four words. Data travels as two words per clock on a double-width bus, which equals one word per clock half. An access occupies two clock cycles. The low two address bits select the first word. Later words follow in linear order and wrap inside the aligned group of four. A command that arrives while the previous access is still in its second cycle is dropped.

Top module: `posted_sram`

## Requirements
- R1: `cmd_ld` high in a free cycle accepts a command: `cmd_rd`=1 is a read, `cmd_rd`=0 is a write. Each access occupies the acceptance cycle and the next one. A load in that next cycle is ignored: it produces no read output and changes no stored word.
- R2: Write data for words 0 and 1 of the burst is taken from `wr_pair` in the acceptance cycle. Words 2 and 3 are taken in the following cycle. In each cycle the lower half of `wr_pair` is the earlier word.
- R3: Word k of a burst (k = 0..3) maps to address {`cmd_addr`[AW-1:2], (`cmd_addr`[1:0]+k) mod 4}, for both reads and writes.
- R4: `rd_valid` is high in the two cycles after an accepted read and low otherwise. The first cycle carries words 0 and 1 and the second carries words 2 and 3, with the lower half of `rd_pair` holding the earlier word. `rd_pair` is zero while `rd_valid` is low.
- R5: Every read returns, for each word, the data of the most recently accepted write to that address. This holds for any mix of reads and writes.
- R6: A read accepted in the first free cycle after a write to the same row returns all four new words.
- R7: After two consecutive writes to one row, and after a later write to another row commits the second one, reads of that row return the later data.
- R8: Reset clears the pending flag and discards a held write. After reset, `rd_valid` is low, and a read of a row whose newest write was still held before reset returns the older committed data. Reset is applied asynchronously and releases on the second rising clock edge after `rst_n` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_ld | input | 1 | Command strobe |
| cmd_rd | input | 1 | 1 = read, 0 = write |
| cmd_addr | input | AW | Word address of the first burst word |
| wr_pair | input | 2*W | Two write words per cycle, earlier word in low half |
| rd_valid | output | 1 | Read words present on `rd_pair` |
| rd_pair | output | 2*W | Two read words per cycle, earlier word in low half |

## Verification
The hardest case to reach is a read that hits the held row while the array still has an older, different copy of that row. Only that case shows whether the bypass works, because a read from the array alone would return stale data. The stimulus writes the same row twice in a row and then reads it at once. It also writes a row and reads it in the very next free cycle using a different start word, so the wrap order applies to the held words. A reset placed between two writes to one row shows that the held burst is discarded and the older committed burst comes back.

// File: rtl/psram_pkg.sv
package psram_pkg;
  localparam int BEATS = 4;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;
endpackage

// File: rtl/psram_seq.sv
// Command sequencer: accepts a command in a free cycle and tracks the
// second cycle of each access plus the two read output cycles.
module psram_seq
  import psram_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_ld,
  input  logic cmd_rd,
  output logic acc_rd,
  output logic acc_wr,
  output logic wr_tail,
  output logic rd_valid,
  output logic rd_second
);
  op_e  cur_op, cur_op_n;
  logic rd_tail, rd_tail_n;
  logic busy, accept;

  assign busy   = (cur_op != OP_IDLE);
  assign accept = cmd_ld & ~busy;
  assign acc_rd = accept & cmd_rd;
  assign acc_wr = accept & ~cmd_rd;

  always_comb begin
    cur_op_n  = OP_IDLE;
    if (acc_rd) cur_op_n = OP_RD;
    if (acc_wr) cur_op_n = OP_WR;
    rd_tail_n = (cur_op == OP_RD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_op  <= OP_IDLE;
      rd_tail <= 1'b0;
    end else begin
      cur_op  <= cur_op_n;
      rd_tail <= rd_tail_n;
    end
  end

  assign wr_tail   = (cur_op == OP_WR);
  assign rd_valid  = (cur_op == OP_RD) | rd_tail;
  assign rd_second = rd_tail;

  // R1
  busy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);
  // R4
  rd_tail_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_op == OP_RD) |=> (rd_tail && rd_valid));
endmodule

// File: rtl/psram_rows.sv
// Behavioural storage array, one row of four words per entry.
module psram_rows
  import psram_pkg::*;
#(
  parameter int W  = 16,
  parameter int RW = 8
) (
  input  logic                clk,
  input  logic                we,
  input  logic [RW-1:0]       wrow,
  input  logic [BEATS*W-1:0]  wdata,
  input  logic [RW-1:0]       rrow,
  output logic [BEATS*W-1:0]  rdata
);
  localparam int ROWS = 1 << RW;

  logic [BEATS*W-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (we) mem[wrow] <= wdata;
  end

  assign rdata = mem[rrow];
endmodule

// File: rtl/psram_hold.sv
// Pending-write holding register with row comparator and commit request.
module psram_hold
  import psram_pkg::*;
#(
  parameter int W  = 16,
  parameter int RW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_wr,
  input  logic               acc_rd,
  input  logic               wr_tail,
  input  logic [RW-1:0]      row_in,
  input  logic [1:0]         start_in,
  input  logic [2*W-1:0]     wr_pair,
  output logic               hit,
  output logic [BEATS*W-1:0] pend_data,
  output logic               commit_en,
  output logic [RW-1:0]      commit_row,
  output logic [BEATS*W-1:0] commit_data
);
  logic               pend_valid, pend_valid_n;
  logic [RW-1:0]      pend_row, pend_row_n;
  logic [1:0]         pend_start, pend_start_n;
  logic [BEATS*W-1:0] data_n;
  logic               data_en;
  logic [1:0]         s0, s1, t2, t3;

  assign s0 = start_in;
  assign s1 = start_in + 2'd1;
  assign t2 = pend_start + 2'd2;
  assign t3 = pend_start + 2'd3;

  always_comb begin
    pend_valid_n = pend_valid;
    pend_row_n   = pend_row;
    pend_start_n = pend_start;
    if (acc_wr) begin
      pend_valid_n = 1'b1;
      pend_row_n   = row_in;
      pend_start_n = start_in;
    end
  end

  always_comb begin
    data_n = pend_data;
    for (int j = 0; j < BEATS; j++) begin
      if (acc_wr  && s0 == 2'(j)) data_n[j*W +: W] = wr_pair[W-1:0];
      if (acc_wr  && s1 == 2'(j)) data_n[j*W +: W] = wr_pair[2*W-1:W];
      if (wr_tail && t2 == 2'(j)) data_n[j*W +: W] = wr_pair[W-1:0];
      if (wr_tail && t3 == 2'(j)) data_n[j*W +: W] = wr_pair[2*W-1:W];
    end
  end

  assign data_en = acc_wr | wr_tail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_row   <= '0;
      pend_start <= 2'd0;
    end else begin
      pend_valid <= pend_valid_n;
      pend_row   <= pend_row_n;
      pend_start <= pend_start_n;
    end
  end

  always_ff @(posedge clk) begin
    if (data_en) pend_data <= data_n;
  end

  assign hit         = acc_rd & pend_valid & (pend_row == row_in);
  assign commit_en   = acc_wr & pend_valid;
  assign commit_row  = pend_row;
  assign commit_data = pend_data;

  // R8
  pend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_valid) |-> $past(acc_wr));
  // R2
  tail_after_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tail |-> pend_valid);
endmodule

// File: rtl/psram_rdout.sv
// Read burst buffer and output word ordering.
module psram_rdout
  import psram_pkg::*;
#(
  parameter int W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [BEATS*W-1:0] src,
  input  logic [1:0]         start_in,
  input  logic               rd_valid,
  input  logic               rd_second,
  output logic [2*W-1:0]     rd_pair
);
  logic [BEATS*W-1:0] rbuf;
  logic [1:0]         rstart;
  logic [1:0]         i0, i1;

  always_ff @(posedge clk) begin
    if (load) rbuf <= src;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rstart <= 2'd0;
    else if (load) rstart <= start_in;
  end

  assign i0 = rstart + {rd_second, 1'b0};
  assign i1 = i0 + 2'd1;

  always_comb begin
    rd_pair = '0;
    if (rd_valid) rd_pair = {rbuf[i1*W +: W], rbuf[i0*W +: W]};
  end
endmodule

// File: rtl/posted_sram.sv
module posted_sram
  import psram_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_ld,
  input  logic            cmd_rd,
  input  logic [AW-1:0]   cmd_addr,
  input  logic [2*W-1:0]  wr_pair,
  output logic            rd_valid,
  output logic [2*W-1:0]  rd_pair
);
  localparam int RW = AW - 2;

  logic [1:0]         rst_sync;
  logic               rst_s;
  logic               acc_rd, acc_wr, wr_tail, rd_second;
  logic [RW-1:0]      row_in;
  logic [1:0]         start_in;
  logic               hit, commit_en;
  logic [RW-1:0]      commit_row;
  logic [BEATS*W-1:0] commit_data, pend_data, arr_rdata, rd_src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  assign row_in   = cmd_addr[AW-1:2];
  assign start_in = cmd_addr[1:0];

  psram_seq u_seq (
    .clk(clk), .rst_n(rst_s), .cmd_ld(cmd_ld), .cmd_rd(cmd_rd),
    .acc_rd(acc_rd), .acc_wr(acc_wr), .wr_tail(wr_tail),
    .rd_valid(rd_valid), .rd_second(rd_second)
  );

  psram_hold #(.W(W), .RW(RW)) u_hold (
    .clk(clk), .rst_n(rst_s), .acc_wr(acc_wr), .acc_rd(acc_rd),
    .wr_tail(wr_tail), .row_in(row_in), .start_in(start_in),
    .wr_pair(wr_pair), .hit(hit), .pend_data(pend_data),
    .commit_en(commit_en), .commit_row(commit_row),
    .commit_data(commit_data)
  );

  psram_rows #(.W(W), .RW(RW)) u_rows (
    .clk(clk), .we(commit_en), .wrow(commit_row), .wdata(commit_data),
    .rrow(row_in), .rdata(arr_rdata)
  );

  assign rd_src = hit ? pend_data : arr_rdata;

  psram_rdout #(.W(W)) u_rdout (
    .clk(clk), .rst_n(rst_s), .load(acc_rd), .src(rd_src),
    .start_in(start_in), .rd_valid(rd_valid), .rd_second(rd_second),
    .rd_pair(rd_pair)
  );

  // R2
  commit_on_write_chk: assert property (@(posedge clk) disable iff (!rst_s)
    commit_en |-> (cmd_ld && !cmd_rd));
  // R4
  rd_burst_len_chk: assert property (@(posedge clk) disable iff (!rst_s)
    acc_rd |=> rd_valid ##1 rd_valid);
  // R4
  rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !rd_valid |-> (rd_pair == '0));
endmodule

// File: tb/posted_sram_test.sv
module posted_sram_test;
  localparam int W      = 16;
  localparam int AW     = 10;
  localparam int CLK_NS = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_ld = 1'b0;
  logic          cmd_rd = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [2*W-1:0] wr_pair = '0;
  logic          rd_valid;
  logic [2*W-1:0] rd_pair;

  posted_sram #(.W(W), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_ld(cmd_ld), .cmd_rd(cmd_rd),
    .cmd_addr(cmd_addr), .wr_pair(wr_pair), .rd_valid(rd_valid),
    .rd_pair(rd_pair)
  );

  always #(CLK_NS/2) clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [W-1:0]   ref_mem [1 << AW];
  logic [2*W-1:0] exp_q [$];
  bit             m_busy = 0, m_wr = 0;
  int             m_row = 0, m_start = 0;
  int unsigned    seed = 32'h1234_5679;

  function automatic int widx(int row, int start, int k);
    return row * 4 + ((start + k) & 3);
  endfunction

  // Drive one cycle, update the reference at the edge, check after it.
  task automatic cycle(input bit ld, input bit rd, input int addr,
                       input logic [2*W-1:0] wp, input string tag);
    logic [2*W-1:0] e;
    bit             ev;
    cmd_ld = ld; cmd_rd = rd; cmd_addr = AW'(addr); wr_pair = wp;
    @(posedge clk);
    if (m_busy) begin
      if (m_wr) begin
        ref_mem[widx(m_row, m_start, 2)] = wp[W-1:0];
        ref_mem[widx(m_row, m_start, 3)] = wp[2*W-1:W];
      end
      m_busy = 0;
    end else if (ld && rst_n) begin
      m_busy  = 1;
      m_wr    = !rd;
      m_row   = addr >> 2;
      m_start = addr & 3;
      if (rd) begin
        exp_q.push_back({ref_mem[widx(m_row, m_start, 1)], ref_mem[widx(m_row, m_start, 0)]});
        exp_q.push_back({ref_mem[widx(m_row, m_start, 3)], ref_mem[widx(m_row, m_start, 2)]});
      end else begin
        ref_mem[widx(m_row, m_start, 0)] = wp[W-1:0];
        ref_mem[widx(m_row, m_start, 1)] = wp[2*W-1:W];
      end
    end
    @(negedge clk);
    ev = (exp_q.size() > 0);
    e  = ev ? exp_q.pop_front() : '0;
    checks++;
    if (rd_valid !== ev || rd_pair !== e) begin
      errors++;
      $display("FAIL %s: rd_valid=%0b rd_pair=%h expected rd_valid=%0b rd_pair=%h",
               tag, rd_valid, rd_pair, ev, e);
    end
  endtask

  task automatic do_wr(input int row, input int st, input logic [2*W-1:0] p0,
                       input logic [2*W-1:0] p1, input string tag);
    cycle(1, 0, row * 4 + st, p0, tag);
    cycle(0, 0, 0, p1, tag);
  endtask

  task automatic do_rd(input int row, input int st, input string tag);
    cycle(1, 1, row * 4 + st, '0, tag);
    cycle(0, 0, 0, '0, tag);
  endtask

  function automatic int unsigned nxt();
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return seed;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) ref_mem[i] = '0;
    @(negedge clk);
    // R8: reset state
    cycle(0, 0, 0, '0, "R8 reset");
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) cycle(0, 0, 0, '0, "R8 reset release");

    // R2 R3: preload rows 0..7 and row 200
    for (int r = 0; r < 8; r++)
      do_wr(r, r & 3, {16'(r*16+1), 16'(r*16)}, {16'(r*16+3), 16'(r*16+2)}, "R2 preload");
    do_wr(200, 0, 32'hAAA1_AAA0, 32'hAAA3_AAA2, "R2 preload");
    do_wr(9, 0, 32'h0, 32'h0, "R2 preload");
    for (int s = 0; s < 4; s++) do_rd(1, s, "R3 wrap order");
    for (int r = 0; r < 8; r++) do_rd(r, 0, "R5 array read");

    // R4: back-to-back reads then idle
    do_rd(2, 1, "R4 back-to-back");
    do_rd(3, 2, "R4 back-to-back");
    cycle(0, 0, 0, '0, "R4 idle");
    cycle(0, 0, 0, '0, "R4 idle");

    // R6: read right after write, other start word
    do_wr(3, 2, 32'h3B01_3B00, 32'h3B03_3B02, "R6 write");
    do_rd(3, 1, "R6 bypass read");

    // R7: consecutive writes same row, then commit elsewhere
    do_wr(4, 0, 32'h4C01_4C00, 32'h4C03_4C02, "R7 first write");
    do_wr(4, 3, 32'h4D01_4D00, 32'h4D03_4D02, "R7 second write");
    do_rd(4, 0, "R7 bypass read");
    do_wr(6, 0, 32'h6E01_6E00, 32'h6E03_6E02, "R7 commit write");
    do_rd(4, 2, "R7 array read");

    // R1: loads in the second cycle of an access are ignored
    cycle(1, 0, 5 * 4, 32'h5F01_5F00, "R1 write head");
    cycle(1, 1, 7 * 4, 32'h5F03_5F02, "R1 read dropped");
    cycle(0, 0, 0, '0, "R1 no read output");
    cycle(1, 1, 2 * 4, '0, "R1 read head");
    cycle(1, 0, 7 * 4, 32'hDEAD_BEEF, "R1 write dropped");
    cycle(0, 0, 0, '0, "R1 quiet");
    do_rd(7, 0, "R1 row unchanged");
    do_rd(5, 0, "R1 write landed");

    // R5: mixed traffic
    for (int n = 0; n < 400; n++) begin
      int unsigned r;
      r = nxt();
      if (r[0]) begin
        cycle(1, 1, int'(r[5:1]), '0, "R5 mixed read");
        cycle(r[8], r[9], int'(r[14:10]), 32'hFFFF_FFFF, "R5 mixed tail");
      end else begin
        do_wr(int'(r[5:3]), int'(r[7:6]), nxt(), nxt(), "R5 mixed write");
      end
      if (r[12]) cycle(0, 0, 0, '0, "R5 mixed idle");
    end

    // R8: held write is discarded by reset
    do_wr(200, 0, 32'hBBB1_BBB0, 32'hBBB3_BBB2, "R8 newer write");
    rst_n = 1'b0;
    cycle(0, 0, 0, '0, "R8 in reset");
    cycle(0, 0, 0, '0, "R8 in reset");
    rst_n = 1'b1;
    exp_q.delete();
    m_busy = 0;
    ref_mem[800] = 16'hAAA0; ref_mem[801] = 16'hAAA1;
    ref_mem[802] = 16'hAAA2; ref_mem[803] = 16'hAAA3;
    for (int i = 0; i < 3; i++) cycle(0, 0, 0, '0, "R8 after reset");
    do_rd(200, 0, "R8 older data");
    do_wr(2, 1, 32'h2A01_2A00, 32'h2A03_2A02, "R8 first write");
    do_rd(1, 0, "R8 other row");
    do_rd(2, 3, "R6 bypass after reset");
    do_wr(1, 0, 32'h1A01_1A00, 32'h1A03_1A02, "R7 commit");
    do_rd(2, 0, "R7 committed row");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule